// File: doc/BRIEF.md
# SPI Memory Slave Serial Front-End

This block is the pin-side half of a serial memory slave. It sits between the four SPI pins plus a pause pin and a byte-wide command decoder. Command, address and write data on the serial input are shifted into bytes, most significant bit first. Each completed byte is handed to the decoder with a one-cycle strobe. In the other direction, the block takes a transmit byte from the decoder at every byte boundary and shifts it out. By default it uses one output pin. If the decoder asks for it, the byte goes out two bits per clock, and the serial input pin is turned around to act as the second output.

All pins are synchronised into a system clock that runs at least four times faster than SCK. Edges are detected in that domain. A frame starts only when chip select falls and ends when it rises. SCK may idle low or high between frames. While the pause pin is held, the block neither shifts nor drives its outputs. The pause can only take effect while SCK is low, and the transfer resumes where it stopped.

Top module: `spi_mem_frontend`

## Requirements
- R1: Each rising SCK edge inside a frame samples `si_in` into the receive shifter, most significant bit first; after every 8 such edges `rx_byte` holds the byte and `rx_valid` is high for exactly one clock.
- R2: At every byte boundary, which is the falling SCK edge after each 8th rising edge in single mode, the block loads `tx_byte` and pulses `tx_req` for one clock. It then presents the byte on `so_out`, most significant bit first, with each following bit changing on a falling SCK edge.
- R3: Clock modes 0 and 3 give the same results: a falling SCK edge that comes before the first rising edge of a frame is ignored.
- R4: While `cs_n` is high, and directly after reset, `so_oe`, `sio_oe`, `rx_valid` and `tx_req` are low, and SCK and `si_in` activity produces no received byte.
- R5: A frame begins only on a high-to-low change of `cs_n`; if `cs_n` is already low when reset ends, clocking is ignored until it has gone high and fallen again.
- R6: A rise of `cs_n` in the middle of a byte discards the partial byte, so the next frame starts at bit 7 again.
- R7: A pause requested with `hold_n` low takes effect only while `cs_n` is low and SCK is low; a request made while SCK is high waits for SCK to go low.
- R8: While paused, SCK edges and `si_in` are ignored and `so_oe` and `sio_oe` are low; after `hold_n` returns high, both directions continue at the bit where they stopped.
- R9: When `dual_en` is high at a byte boundary, that byte is sent two bits per falling edge, with bit 7 on `sio_out` and bit 6 on `so_out` first. The byte takes 4 falling edges, `sio_oe` is high, and no `rx_valid` is raised for it. `dual_en` is sampled again at each byte boundary.
- R10: `so_oe` is low during the first byte of a frame and high from the first byte boundary until the end of the frame, except while paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si_in | input | 1 | Serial data in (single mode) |
| hold_n | input | 1 | Pause request, active low |
| so_out | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so_out |
| sio_out | output | 1 | Second data output in dual mode |
| sio_oe | output | 1 | Drive enable for sio_out |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-clock strobe for rx_byte |
| tx_byte | input | 8 | Next byte to transmit |
| tx_req | output | 1 | One-clock pulse when tx_byte was taken |
| dual_en | input | 1 | Send the next byte two bits per edge |

## Verification
The vector table runs frames in both clock modes and both output widths, and uses bytes of all ones, all zeros, alternating bits and single set bits. Mode 0 frames are set against mode 3 frames to expose a miscounted initial falling edge. The patterns also expose a swapped bit order or pin pairing in dual output. The directed tests add several cases:
- clocking with chip select high, or with chip select already low at reset;
- a frame aborted after three bits;
- pauses in both directions, and a pause requested with SCK high;
- a dual byte followed by a single byte in one frame, which shows that the width is taken per byte.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  // qualified serial clock events, one cycle wide, in the system domain
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_ev_t;

  localparam int unsigned SFE_MIN_SYNC = 2;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
        else        chain_q <= {chain_q[STAGES-2:0], d[i]};
      end
      assign q[i] = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sfe_ctrl.sv
module sfe_ctrl
  import sfe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    s_cs_n,
  input  logic    s_sck,
  input  logic    s_hold_n,
  output logic    frame_on,
  output logic    hold_act,
  output sck_ev_t ev
);
  logic sck_q, cs_q, frame_q, hold_q, armed_q;
  logic frame_d, hold_d, armed_d;
  logic rise_raw, fall_raw, live;

  always_comb begin
    rise_raw = s_sck & ~sck_q;
    fall_raw = ~s_sck & sck_q;
    live     = frame_q & ~s_cs_n & ~hold_q;

    // frame opens only on a seen falling chip select
    frame_d = frame_q;
    if (s_cs_n)                frame_d = 1'b0;
    else if (cs_q && !s_cs_n)  frame_d = 1'b1;

    // pause may begin only with the clock low, ends when released
    if (!frame_q || s_cs_n)    hold_d = 1'b0;
    else if (hold_q)           hold_d = ~s_hold_n;
    else                       hold_d = ~s_hold_n & ~s_sck;

    // falling edges count only after the first rising edge of a frame
    armed_d = armed_q;
    if (!frame_q || s_cs_n)    armed_d = 1'b0;
    else if (live && rise_raw) armed_d = 1'b1;

    ev.rise = live & rise_raw;
    ev.fall = live & fall_raw & armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      frame_q <= 1'b0;
      hold_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sck_q   <= s_sck;
      cs_q    <= s_cs_n;
      frame_q <= frame_d;
      hold_q  <= hold_d;
      armed_q <= armed_d;
    end
  end

  assign frame_on = frame_q;
  assign hold_act = hold_q;
endmodule

// File: rtl/sfe_rx.sv
module sfe_rx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              rise,
  input  logic              dual_act,
  input  logic              s_si,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d, sh_n, byte_q, byte_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              valid_q, valid_d;

  always_comb begin
    sh_n    = {sh_q[DATA_W-2:0], s_si};
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    valid_d = 1'b0;
    if (!frame_on) begin
      cnt_d = '0;
    end else if (rise && !dual_act) begin
      sh_d  = sh_n;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        byte_d  = sh_n;
        valid_d = 1'b1;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
      valid_q <= valid_d;
    end
  end

  assign rx_byte  = byte_q;
  assign rx_valid = valid_q;
endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_on,
  input  logic              hold_act,
  input  logic              fall,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              dual_en,
  output logic              so_out,
  output logic              so_oe,
  output logic              sio_out,
  output logic              sio_oe,
  output logic              tx_req,
  output logic              dual_act
);
  localparam int unsigned CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LIM_ONE = CW'(DATA_W - 1);
  localparam logic [CW-1:0] LIM_TWO = CW'(DATA_W / 2 - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d, lim;
  logic              wide_q, wide_d, loaded_q, loaded_d, req_q, req_d;

  always_comb begin
    lim      = wide_q ? LIM_TWO : LIM_ONE;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    wide_d   = wide_q;
    loaded_d = loaded_q;
    req_d    = 1'b0;
    if (!frame_on) begin
      sh_d     = '0;
      cnt_d    = '0;
      wide_d   = 1'b0;
      loaded_d = 1'b0;
    end else if (fall) begin
      if (cnt_q == lim) begin
        sh_d     = tx_byte;
        wide_d   = dual_en;
        loaded_d = 1'b1;
        cnt_d    = '0;
        req_d    = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sh_d  = wide_q ? {sh_q[DATA_W-3:0], 2'b00} : {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      wide_q   <= 1'b0;
      loaded_q <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      cnt_q    <= cnt_d;
      wide_q   <= wide_d;
      loaded_q <= loaded_d;
      req_q    <= req_d;
    end
  end

  assign sio_out  = sh_q[DATA_W-1];
  assign so_out   = wide_q ? sh_q[DATA_W-2] : sh_q[DATA_W-1];
  assign so_oe    = frame_on & loaded_q & ~hold_act;
  assign sio_oe   = frame_on & loaded_q & ~hold_act & wide_q;
  assign dual_act = frame_on & loaded_q & wide_q;
  assign tx_req   = req_q;
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import sfe_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si_in,
  input  logic              hold_n,
  output logic              so_out,
  output logic              so_oe,
  output logic              sio_out,
  output logic              sio_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_req,
  input  logic              dual_en
);
  localparam int unsigned NSTG = (SYNC_STAGES < SFE_MIN_SYNC) ? SFE_MIN_SYNC : SYNC_STAGES;

  logic [1:0] rst_pipe_q;
  logic       rst_sys_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sys_n = rst_pipe_q[1];

  logic [3:0] pins_s;
  logic       s_cs_n, s_hold_n, s_sck, s_si;

  // order: chip select, pause, clock, data; select resets low so a low pin at reset opens no frame
  sfe_sync #(.W(4), .STAGES(NSTG), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst_n(rst_sys_n),
    .d({cs_n, hold_n, sck, si_in}),
    .q(pins_s)
  );
  assign {s_cs_n, s_hold_n, s_sck, s_si} = pins_s;

  logic    frame_on, hold_act, dual_act;
  sck_ev_t ev;

  sfe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sys_n),
    .s_cs_n(s_cs_n), .s_sck(s_sck), .s_hold_n(s_hold_n),
    .frame_on(frame_on), .hold_act(hold_act), .ev(ev)
  );

  sfe_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_sys_n),
    .frame_on(frame_on), .rise(ev.rise), .dual_act(dual_act), .s_si(s_si),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  sfe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_sys_n),
    .frame_on(frame_on), .hold_act(hold_act), .fall(ev.fall),
    .tx_byte(tx_byte), .dual_en(dual_en),
    .so_out(so_out), .so_oe(so_oe), .sio_out(sio_out), .sio_oe(sio_oe),
    .tx_req(tx_req), .dual_act(dual_act)
  );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rst_n,
  input logic frame_on,
  input logic hold_act,
  input logic s_sck,
  input logic so_oe,
  input logic sio_oe,
  input logic rx_valid,
  input logic tx_req
);
  p_rx_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_req_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |-> (!so_oe && !sio_oe));

  p_hold_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_act) |-> ($past(!s_sck) && $past(frame_on)));

  p_hold_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> (!so_oe && !sio_oe));

  p_dual_norx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe |-> !rx_valid);

  p_dual_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sio_oe |-> so_oe);
endmodule

bind spi_mem_frontend sfe_checker u_chk (
  .clk(clk), .rst_n(rst_sys_n), .frame_on(frame_on), .hold_act(hold_act),
  .s_sck(s_sck), .so_oe(so_oe), .sio_oe(sio_oe), .rx_valid(rx_valid), .tx_req(tx_req)
);

// File: tb/spi_mem_frontend_tb.sv
module spi_mem_frontend_tb;
  localparam int HALF = 8;
  localparam int NV   = 6;
  // {mode3, dual, command, response}
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hA5, 8'h3C},
    {1'b1, 1'b0, 8'h5A, 8'hC3},
    {1'b0, 1'b1, 8'h0B, 8'h96},
    {1'b1, 1'b1, 8'hFF, 8'h00},
    {1'b0, 1'b0, 8'h00, 8'hFF},
    {1'b0, 1'b1, 8'h81, 8'h7E}
  };

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si_in, hold_n, dual_en;
  logic [7:0] tx_byte, rx_byte;
  logic so_out, so_oe, sio_out, sio_oe, rx_valid, tx_req;

  always #5 clk = ~clk;

  spi_mem_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si_in(si_in), .hold_n(hold_n),
    .so_out(so_out), .so_oe(so_oe), .sio_out(sio_out), .sio_oe(sio_oe),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_byte(tx_byte), .tx_req(tx_req),
    .dual_en(dual_en)
  );

  int total = 0, bad = 0, rx_cnt = 0, req_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  logic done = 1'b0;

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_byte; end
    if (tx_req) req_cnt <= req_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic xbit(input logic b, output logic so_s, output logic sio_s,
                      output logic soe_s, output logic sioe_s);
    @(negedge clk) sck = 1'b0;
    repeat (2) @(negedge clk);
    si_in = b;
    repeat (HALF - 2) @(negedge clk);
    so_s = so_out; sio_s = sio_out; soe_s = so_oe; sioe_s = sio_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic any_oe);
    logic a, b, c, d;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xbit(v[i], a, b, c, d);
      any_oe = any_oe | c | d;
    end
  endtask

  task automatic read_single(output logic [7:0] v, output logic all_oe);
    logic a, b, c, d;
    v = 8'h00; all_oe = 1'b1;
    for (int i = 0; i < 8; i++) begin
      xbit(1'b0, a, b, c, d);
      v = {v[6:0], a}; all_oe = all_oe & c;
    end
  endtask

  task automatic read_dual(input int n, output logic [7:0] v, output logic all_oe);
    logic a, b, c, d;
    v = 8'h00; all_oe = 1'b1;
    for (int i = 0; i < n; i++) begin
      xbit(1'b0, a, b, c, d);
      v = {v[5:0], b, a}; all_oe = all_oe & c & d;
    end
  endtask

  task automatic frame_begin(input logic m3);
    @(negedge clk) sck = m3;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_end(input logic m3);
    @(negedge clk);
    if (!m3) begin sck = 1'b0; repeat (HALF) @(negedge clk); end
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic pause_toggle(input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b1; si_in = ~si_in; repeat (HALF) @(negedge clk);
      sck = 1'b0; repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic any, all, m3, dl, a, b, c, d;
    logic [7:0] cmd, rsp, v;
    int r0, q0;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si_in = 1'b0; hold_n = 1'b1;
    dual_en = 1'b0; tx_byte = 8'h00;
    repeat (10) @(negedge clk);
    chk("R4 reset so_oe", int'(so_oe), 0);
    chk("R4 reset sio_oe", int'(sio_oe), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 after reset strobes", int'({rx_valid, tx_req, so_oe, sio_oe}), 0);

    // R5: select already low at reset: no frame
    send_byte(8'hA5, any);
    repeat (4) @(negedge clk);
    chk("R5 no byte without select fall", rx_cnt, 0);
    chk("R5 no drive without select fall", int'(any), 0);
    frame_end(1'b0);

    // R4: clocking while deselected
    r0 = rx_cnt;
    send_byte(8'hFF, any);
    repeat (4) @(negedge clk);
    chk("R4 deselected clocks ignored", rx_cnt - r0, 0);
    chk("R4 deselected outputs off", int'(any), 0);

    for (int i = 0; i < NV; i++) begin
      m3 = VEC[i][17]; dl = VEC[i][16]; cmd = VEC[i][15:8]; rsp = VEC[i][7:0];
      tx_byte = rsp; dual_en = dl; r0 = rx_cnt; q0 = req_cnt;
      frame_begin(m3);
      send_byte(cmd, any);
      repeat (2) @(negedge clk);
      chk("R10 first byte undriven", int'(any), 0);
      chk(m3 ? "R3 rx count" : "R1 rx count", rx_cnt - r0, 1);
      chk(m3 ? "R3 rx byte" : "R1 rx byte", int'(rx_last), int'(cmd));
      if (dl) begin
        read_dual(4, v, all);
        chk("R9 dual byte", int'(v), int'(rsp));
        chk("R9 both pins driven", int'(all), 1);
        chk("R9 no rx strobe in dual", rx_cnt - r0, 1);
      end else begin
        read_single(v, all);
        chk(m3 ? "R3 tx byte" : "R2 tx byte", int'(v), int'(rsp));
        chk("R10 so driven after boundary", int'(all), 1);
      end
      chk("R2 one tx_req per boundary", req_cnt - q0, 1);
      frame_end(m3);
      chk("R4 outputs off after frame", int'({so_oe, sio_oe}), 0);
    end

    // R6: abort mid byte
    dual_en = 1'b0;
    frame_begin(1'b0);
    for (int i = 0; i < 3; i++) xbit(1'b1, a, b, c, d);
    frame_end(1'b0);
    r0 = rx_cnt;
    frame_begin(1'b0);
    send_byte(8'h42, any);
    repeat (2) @(negedge clk);
    chk("R6 one byte after abort", rx_cnt - r0, 1);
    chk("R6 realigned byte", int'(rx_last), 8'h42);
    frame_end(1'b0);

    // R8: pause in both directions
    tx_byte = 8'hB4; r0 = rx_cnt;
    frame_begin(1'b0);
    for (int i = 7; i >= 4; i--) xbit(cmd_bit(8'hC6, i), a, b, c, d);
    sck = 1'b0; repeat (4) @(negedge clk);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    pause_toggle(3);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    for (int i = 3; i >= 0; i--) xbit(cmd_bit(8'hC6, i), a, b, c, d);
    repeat (2) @(negedge clk);
    chk("R8 rx byte across pause", int'(rx_last), 8'hC6);
    chk("R8 rx count across pause", rx_cnt - r0, 1);
    v = 8'h00;
    for (int i = 0; i < 4; i++) begin xbit(1'b0, a, b, c, d); v = {v[6:0], a}; end
    sck = 1'b0; repeat (4) @(negedge clk);
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    chk("R8 so off while paused", int'(so_oe), 0);
    pause_toggle(2);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    chk("R8 so back after pause", int'(so_oe), 1);
    for (int i = 0; i < 4; i++) begin xbit(1'b0, a, b, c, d); v = {v[6:0], a}; end
    chk("R8 tx byte across pause", int'(v), 8'hB4);
    frame_end(1'b0);

    // R7: pause requested with SCK high waits for SCK low
    tx_byte = 8'h69;
    frame_begin(1'b0);
    send_byte(8'h10, any);
    v = 8'h00;
    for (int i = 0; i < 3; i++) begin xbit(1'b0, a, b, c, d); v = {v[6:0], a}; end
    hold_n = 1'b0; repeat (HALF) @(negedge clk);
    chk("R7 no pause with sck high", int'(so_oe), 1);
    sck = 1'b0; repeat (HALF) @(negedge clk);
    chk("R7 pause once sck low", int'(so_oe), 0);
    hold_n = 1'b1; repeat (HALF) @(negedge clk);
    for (int i = 0; i < 5; i++) begin xbit(1'b0, a, b, c, d); v = {v[6:0], a}; end
    chk("R7 tx byte intact", int'(v), 8'h69);
    frame_end(1'b0);

    // R9: width chosen per byte: dual then single
    tx_byte = 8'hD2; dual_en = 1'b1;
    frame_begin(1'b1);
    send_byte(8'h3B, any);
    xbit(1'b0, a, b, c, d);
    v = {6'b0, b, a};
    tx_byte = 8'h5E; dual_en = 1'b0;
    for (int i = 0; i < 3; i++) begin xbit(1'b0, a, b, c, d); v = {v[5:0], b, a}; end
    chk("R9 dual byte before switch", int'(v), 8'hD2);
    read_single(v, all);
    chk("R9 single byte after dual", int'(v), 8'h5E);
    chk("R9 sio released in single", int'(sio_oe), 0);
    frame_end(1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic cmd_bit(input logic [7:0] v, input int i);
    return v[i];
  endfunction
endmodule